// File: doc/BRIEF.md
# Watchdog Timer with Cascaded Prescaler and Postscaler

This block is a watchdog that counts ticks from a slow free-running oscillator of about 31 kHz. The tick arrives as a one-cycle enable on the system clock. A 16-bit prescaler divides the tick stream by a power of two between 128 and 65536. When the shared postscaler is assigned to the watchdog, a second stage divides further by 1 to 128. When the last active stage wraps, the block emits a one-cycle time-out pulse. The chain then starts again from zero. Because the tick source is an untrimmed oscillator, the time-out period is only as accurate as that oscillator.

The watchdog runs when either of two enables is set. One is a configuration input that forces the watchdog on. The other is a software bit in a small control register that also holds the 4-bit prescale select. Several events clear the count: a clear command, a detected oscillator failure, a disable, and a wake from sleep when the system clock is not a crystal. With a crystal clock the clear after wake is left to the start-up hold. While the oscillator start-up timer is busy, the block is held cleared. It resumes counting once that input drops, but only if it is enabled.

A three-state controller sequences the block. OFF means disabled, with the chain cleared. HOLD means the start-up timer is busy, with the chain cleared. RUN means counting. Any state goes to HOLD whenever the start-up busy input is high. Otherwise any state goes to OFF when neither enable is set. Otherwise any state goes to RUN.

Top module: `wdt_timer`

## Requirements
- R1: After reset the control register reads `ctl_rdata` = 5'b01000 (software enable bit 0 = 0, select field bits 4:1 = 4) and `timeout` is low.
- R2: A cycle with `ctl_wr` high loads `ctl_wdata` into the control register, and the new value reads back on `ctl_rdata` from the next cycle. Bit 0 is the software enable and bits 4:1 are the prescale select.
- R3: With `post_assign` = 0, `timeout` rises one cycle after the N-th `osc_tick` counted from a clear, where N = 2^min(PRE_MIN_LOG2+select, PRE_MAX_LOG2), i.e. 128..65536 by default.
- R4: With `post_assign` = 1, the period becomes N * 2^`post_sel`, so a post select of 0..7 gives ratios 1..128.
- R5: `timeout` is a single-cycle pulse. After it the chain restarts from zero, and the next pulse follows after a full period.
- R6: With `cfg_hw_en` = 1 the watchdog runs, and the software enable bit has no effect.
- R7: With `cfg_hw_en` = 0 the software enable bit starts and stops the watchdog. While disabled no `timeout` occurs, and disabling clears the count.
- R8: A `clr_cmd` or `osc_fail` pulse clears the prescaler and postscaler, and no time-out occurs in that cycle.
- R9: A `sleep_exit` pulse clears the chain when `xtal_src` = 0. It leaves the count intact when `xtal_src` = 1.
- R10: While `ost_busy` = 1 the chain is held cleared and ignores ticks. After `ost_busy` falls it counts from zero if enabled.
- R11: The count advances only on cycles with `osc_tick` high, and a time-out always follows a tick cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle enable per slow oscillator period |
| cfg_hw_en | input | 1 | Configuration enable; forces the watchdog on |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control write data: [4:1] select, [0] software enable |
| ctl_rdata | output | 5 | Control register contents |
| post_assign | input | 1 | 1 = shared postscaler belongs to the watchdog |
| post_sel | input | 3 | Postscaler ratio select (power of two) |
| clr_cmd | input | 1 | Clear-watchdog command pulse |
| osc_fail | input | 1 | Oscillator-failure detect pulse |
| sleep_exit | input | 1 | Wake-from-sleep event pulse |
| xtal_src | input | 1 | 1 = system clock is a crystal-type source |
| ost_busy | input | 1 | Oscillator start-up timer is counting |
| timeout | output | 1 | One-cycle time-out pulse |

## Verification
A count that is off by one, or a stage terminal decoded from the wrong select, shows up as a time-out that arrives one or more ticks early or late in the first period after a clear. For that reason every period is measured in ticks from a known clear point. A clear source or enable that fails to reset the chain is caught by the tick count of the next time-out after that event. A state stuck in HOLD or OFF shows up as a missing pulse within twice the expected period. A pulse that is too wide is seen in the cycle right after it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int SEL_W = 4;
    localparam int CTL_W = SEL_W + 1;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HOLD = 2'd1,
        ST_RUN  = 2'd2
    } wdt_state_t;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             sw_en;
    } wdt_ctrl_t;
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
    import wdt_pkg::*;
#(
    parameter logic [SEL_W-1:0] RST_SEL = 4'd4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr,
    input  wdt_ctrl_t wdata,
    output wdt_ctrl_t q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sel   <= RST_SEL;
            q.sw_en <= 1'b0;
        end else if (wr) begin
            q <= wdata;
        end
    end
endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       ost_busy,
    output wdt_state_t state
);
    wdt_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:  nxt = ost_busy ? ST_HOLD : (en ? ST_RUN : ST_OFF);
            ST_HOLD: nxt = ost_busy ? ST_HOLD : (en ? ST_RUN : ST_OFF);
            ST_RUN:  nxt = ost_busy ? ST_HOLD : (en ? ST_RUN : ST_OFF);
            default: nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end
endmodule

// File: rtl/wdt_divider.sv
module wdt_divider #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] last,
    output logic         wrap
);
    logic [W-1:0] cnt;
    logic         hit;

    assign hit  = step && (cnt == last);
    assign wrap = hit && !clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (hit)  cnt <= '0;
        else if (step) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int               PRE_MIN_LOG2 = 7,
    parameter int               PRE_MAX_LOG2 = 16,
    parameter int               POST_SEL_W   = 3,
    parameter logic [SEL_W-1:0] RST_SEL      = 4'd4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  osc_tick,
    input  logic                  cfg_hw_en,
    input  logic                  ctl_wr,
    input  logic [CTL_W-1:0]      ctl_wdata,
    output logic [CTL_W-1:0]      ctl_rdata,
    input  logic                  post_assign,
    input  logic [POST_SEL_W-1:0] post_sel,
    input  logic                  clr_cmd,
    input  logic                  osc_fail,
    input  logic                  sleep_exit,
    input  logic                  xtal_src,
    input  logic                  ost_busy,
    output logic                  timeout
);
    localparam int PRE_CNT_W   = PRE_MAX_LOG2;
    localparam int POST_CNT_W  = (1 << POST_SEL_W) - 1;
    localparam int POST_FULL_W = POST_CNT_W + 1;

    wdt_ctrl_t  ctl;
    wdt_state_t state;
    logic       en, run_ok, clr_any, fire;
    logic       pre_wrap, post_wrap;
    int         pre_sh;
    logic [PRE_CNT_W:0]     pre_full;
    logic [PRE_CNT_W-1:0]   pre_last;
    logic [POST_FULL_W-1:0] post_full;
    logic [POST_CNT_W-1:0]  post_last;

    wdt_ctrl_reg #(.RST_SEL(RST_SEL)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ctl_wr),
        .wdata (wdt_ctrl_t'(ctl_wdata)),
        .q     (ctl)
    );
    assign ctl_rdata = ctl;

    // configuration enable dominates the software bit
    assign en = cfg_hw_en | ctl.sw_en;

    wdt_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .ost_busy (ost_busy),
        .state    (state)
    );

    assign run_ok  = (state == ST_RUN) && en && !ost_busy;
    assign clr_any = clr_cmd | osc_fail | (sleep_exit & ~xtal_src) | ~run_ok;

    // prescaler terminal: 2^(min+sel) saturating at 2^max
    always_comb begin
        pre_sh = PRE_MIN_LOG2 + int'(ctl.sel);
        if (pre_sh > PRE_MAX_LOG2) pre_sh = PRE_MAX_LOG2;
        pre_full = {{PRE_CNT_W{1'b0}}, 1'b1} << pre_sh;
        pre_last = PRE_CNT_W'(pre_full - 1'b1);
    end

    always_comb begin
        post_full = {{POST_CNT_W{1'b0}}, 1'b1} << post_sel;
        post_last = POST_CNT_W'(post_full - 1'b1);
    end

    wdt_divider #(.W(PRE_CNT_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_any),
        .step  (osc_tick & run_ok),
        .last  (pre_last),
        .wrap  (pre_wrap)
    );

    wdt_divider #(.W(POST_CNT_W)) u_post (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_any | ~post_assign),
        .step  (pre_wrap & post_assign),
        .last  (post_last),
        .wrap  (post_wrap)
    );

    assign fire = post_assign ? post_wrap : pre_wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) timeout <= 1'b0;
        else        timeout <= fire;
    end
endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk
    import wdt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             osc_tick,
    input logic             cfg_hw_en,
    input logic             ctl_wr,
    input logic [CTL_W-1:0] ctl_wdata,
    input logic [CTL_W-1:0] ctl_rdata,
    input logic             clr_cmd,
    input logic             osc_fail,
    input logic             sleep_exit,
    input logic             xtal_src,
    input logic             ost_busy,
    input logic             timeout
);
    a_r2_write_takes: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (ctl_rdata == $past(ctl_wdata)));

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout);

    a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_hw_en && !ctl_rdata[0]) |=> !timeout);

    a_r8_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cmd || osc_fail) |=> !timeout);

    a_r9_wake_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_exit && !xtal_src) |=> !timeout);

    a_r10_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ost_busy |=> !timeout);

    a_r11_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_tick |=> !timeout);
endmodule

bind wdt_timer wdt_timer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_tick   (osc_tick),
    .cfg_hw_en  (cfg_hw_en),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (ctl_wdata),
    .ctl_rdata  (ctl_rdata),
    .clr_cmd    (clr_cmd),
    .osc_fail   (osc_fail),
    .sleep_exit (sleep_exit),
    .xtal_src   (xtal_src),
    .ost_busy   (ost_busy),
    .timeout    (timeout)
);

// File: tb/wdt_timer_test.sv
module wdt_timer_test;
    localparam int MINL = 2;
    localparam int MAXL = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0, cfg_hw_en = 1'b0, ctl_wr = 1'b0;
    logic [4:0] ctl_wdata = '0;
    logic [4:0] ctl_rdata;
    logic       post_assign = 1'b0;
    logic [2:0] post_sel = '0;
    logic       clr_cmd = 1'b0, osc_fail = 1'b0, sleep_exit = 1'b0;
    logic       xtal_src = 1'b0, ost_busy = 1'b0;
    logic       timeout;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    wdt_timer #(.PRE_MIN_LOG2(MINL), .PRE_MAX_LOG2(MAXL)) uut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .cfg_hw_en(cfg_hw_en),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .post_assign(post_assign), .post_sel(post_sel), .clr_cmd(clr_cmd),
        .osc_fail(osc_fail), .sleep_exit(sleep_exit), .xtal_src(xtal_src),
        .ost_busy(ost_busy), .timeout(timeout)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one tick: raised for one edge, result sampled after that edge
    task automatic tick1(output logic to);
        @(negedge clk) osc_tick = 1'b1;
        @(negedge clk) osc_tick = 1'b0;
        to = timeout;
    endtask

    task automatic ticks(input int n, output int seen);
        logic to;
        seen = 0;
        for (int i = 0; i < n; i++) begin
            tick1(to);
            if (to) seen++;
        end
    endtask

    task automatic wr_ctl(input logic [3:0] sel, input logic sw);
        @(negedge clk) begin ctl_wr = 1'b1; ctl_wdata = {sel, sw}; end
        @(negedge clk) ctl_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_clr;
        @(negedge clk) clr_cmd = 1'b1;
        @(negedge clk) clr_cmd = 1'b0;
    endtask

    // ticks until the next time-out; checks against exp
    task automatic measure(input int exp, input string tag);
        logic to;
        int n;
        n = 0;
        to = 1'b0;
        while (!to && n < 2 * exp + 8) begin
            tick1(to);
            n++;
        end
        check(to && n == exp, tag, n, exp);
        @(negedge clk);
        check(timeout == 1'b0, "R5 pulse width", timeout, 0);
    endtask

    function automatic int pre_ratio(input int sel);
        int s;
        s = MINL + sel;
        if (s > MAXL) s = MAXL;
        return 1 << s;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ctl_rdata == 5'b01000, "R1 reset register", ctl_rdata, 8);
        check(timeout == 1'b0, "R1 reset timeout", timeout, 0);
        ticks(80, seen);
        check(seen == 0, "R1/R7 disabled after reset", seen, 0);

        // R2 write/readback
        wr_ctl(4'd11, 1'b1);
        check(ctl_rdata == 5'b10111, "R2 readback", ctl_rdata, 23);

        // R3 near-exhaustive prescale sweep, R5 restart
        for (int s = 0; s < 16; s++) begin
            wr_ctl(4'(s), 1'b1);
            pulse_clr();
            measure(pre_ratio(s), $sformatf("R3 sel=%0d", s));
            measure(pre_ratio(s), $sformatf("R5 restart sel=%0d", s));
        end

        // R4 postscaler sweep
        post_assign = 1'b1;
        for (int p = 0; p < 8; p++) begin
            post_sel = 3'(p);
            wr_ctl(4'd0, 1'b1);
            pulse_clr();
            measure(pre_ratio(0) << p, $sformatf("R4 post=%0d", p));
        end
        post_sel = 3'd2;
        wr_ctl(4'd2, 1'b1);
        pulse_clr();
        measure(pre_ratio(2) << 2, "R4 sel2 post2");
        post_assign = 1'b0;

        // R7 software enable and disable clears
        wr_ctl(4'd0, 1'b0);
        ticks(40, seen);
        check(seen == 0, "R7 off no timeout", seen, 0);
        wr_ctl(4'd0, 1'b1);
        measure(4, "R7 sw start");
        ticks(3, seen);
        wr_ctl(4'd0, 1'b0);
        wr_ctl(4'd0, 1'b1);
        measure(4, "R7 disable clears");

        // R6 hardware enable overrides software bit
        cfg_hw_en = 1'b1;
        wr_ctl(4'd1, 1'b0);
        pulse_clr();
        measure(8, "R6 hw runs sw=0");

        // R8 clear sources
        ticks(5, seen);
        pulse_clr();
        measure(8, "R8 clr_cmd");
        ticks(5, seen);
        @(negedge clk) osc_fail = 1'b1;
        @(negedge clk) osc_fail = 1'b0;
        measure(8, "R8 osc_fail");

        // R9 sleep exit
        ticks(5, seen);
        @(negedge clk) sleep_exit = 1'b1;
        @(negedge clk) sleep_exit = 1'b0;
        measure(8, "R9 wake rc clears");
        xtal_src = 1'b1;
        ticks(5, seen);
        @(negedge clk) sleep_exit = 1'b1;
        @(negedge clk) sleep_exit = 1'b0;
        measure(3, "R9 wake xtal keeps");

        // R10 start-up hold
        ticks(5, seen);
        @(negedge clk) ost_busy = 1'b1;
        ticks(20, seen);
        check(seen == 0, "R10 hold quiet", seen, 0);
        @(negedge clk) ost_busy = 1'b0;
        @(negedge clk);
        measure(8, "R10 resume from zero");
        cfg_hw_en = 1'b0;
        wr_ctl(4'd1, 1'b0);
        @(negedge clk) ost_busy = 1'b1;
        @(negedge clk) ost_busy = 1'b0;
        ticks(20, seen);
        check(seen == 0, "R10 stays off when disabled", seen, 0);

        // R11 no ticks, no count
        cfg_hw_en = 1'b1;
        pulse_clr();
        ticks(7, seen);
        repeat (50) @(negedge clk);
        check(timeout == 1'b0, "R11 idle no timeout", timeout, 0);
        measure(1, "R11 count held without ticks");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule